// File: doc/BRIEF.md
# Combinational Multi-Operation ALU

This block is a purely combinational arithmetic-logic unit for a 32-bit datapath. It takes two operands and a 4-bit operation selector. It returns a result word and a 4-bit error code. It has no clock, no reset and no storage, so both outputs follow any change on any input.

Arithmetic covers unsigned add and subtract, and two's complement add, subtract, multiply and divide. Logic covers AND, OR and NOT, each in two forms. The boolean form treats a nonzero operand as true and returns 0 or 1. The bitwise form works bit by bit. Selector values 12 through 15 produce zero.

The error code separates four outcomes:

| Code | Meaning |
|---|---|
| 0 | clean result |
| 1 | result above the representable range |
| 2 | result below the representable range |
| 3 | division with a zero divisor |

Operand A is always the left operand and operand B the right one.

Top module: `mop_alu`

## Requirements
- R1: Selector 0000 returns A+B modulo 2^32. The error code is 0001 exactly when the sum carries out of bit 31, and 0000 otherwise.
- R2: Selector 0001 returns A−B modulo 2^32. The error code is 0010 exactly when B is greater than A as unsigned values, and 0000 otherwise.
- R3: Selector 0010 returns the two's complement sum A+B modulo 2^32. The error code is 0001 when the true sum exceeds 2^31−1, 0010 when it is below −2^31, and 0000 otherwise.
- R4: Selector 0011 returns the two's complement difference A−B modulo 2^32, with the same range rule and codes as R3.
- R5: Selector 0100 returns the low 32 bits of the two's complement product A×B. The error code is 0001 when the true product exceeds 2^31−1, 0010 when it is below −2^31, and 0000 otherwise.
- R6: Selector 0101 returns the two's complement quotient A/B, truncated toward zero, with error 0000 when B is nonzero and the case of R8 does not apply.
- R7: Selector 0101 with B equal to zero returns an all-zero result and error 0011.
- R8: Selector 0101 with A = 0x80000000 and B = 0xFFFFFFFF returns 0x80000000 and error 0001.
- R9: Selectors 0110 (boolean AND) and 1000 (boolean OR) return 0x00000001 when the boolean condition on (A≠0, B≠0) holds, and 0x00000000 otherwise.
- R10: Selectors 0111 (bitwise AND) and 1001 (bitwise OR) return A&B and A|B respectively.
- R11: Selector 1010 returns 0x00000001 if A is zero and 0x00000000 otherwise. Selector 1011 returns ~A. B has no effect on either.
- R12: Selectors 1100 to 1111 return zero. Every selector from 0110 upward reports error 0000.
- R13: Both outputs are pure functions of the current inputs. A change on any input shows at the outputs without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 32 | Left operand (A) |
| opb_i | input | 32 | Right operand (B) |
| op_i | input | 4 | Operation selector |
| res_o | output | 32 | Result word |
| err_o | output | 4 | Error code |

## Verification
The bench builds the block with its default width of 32.

At that width the exact range boundaries can be reached with directed operands:
- 0x7FFFFFFF+1 and 0x80000000−1 for signed add and subtract;
- ±2^32 products for multiply;
- the most-negative-by-minus-one quotient for divide.

The bench also reaches the unsigned carry and borrow edges, including equal operands.

Operand order is probed with asymmetric pairs, and truncation toward zero with quotients of mixed sign. NOT operations are applied twice with different B values to show that B has no effect.

// File: rtl/mop_alu_pkg.sv
package mop_alu_pkg;
  localparam int OP_W  = 4;
  localparam int ERR_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADDU = 4'd0,  OP_SUBU = 4'd1,  OP_ADDS = 4'd2,  OP_SUBS = 4'd3,
    OP_MULS = 4'd4,  OP_DIVS = 4'd5,  OP_LAND = 4'd6,  OP_BAND = 4'd7,
    OP_LOR  = 4'd8,  OP_BOR  = 4'd9,  OP_LNOT = 4'd10, OP_BNOT = 4'd11
  } op_e;

  localparam logic [ERR_W-1:0] ERR_NONE = 4'd0;
  localparam logic [ERR_W-1:0] ERR_OVF  = 4'd1;
  localparam logic [ERR_W-1:0] ERR_UNF  = 4'd2;
  localparam logic [ERR_W-1:0] ERR_DIV0 = 4'd3;
endpackage

// File: rtl/mop_alu_addsub.sv
module mop_alu_addsub
  import mop_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [W-1:0]     res_o,
  output logic [ERR_W-1:0] err_o
);
  logic [W:0] u_add, u_sub, s_add, s_sub;

  assign u_add = {1'b0, a_i} + {1'b0, b_i};
  assign u_sub = {1'b0, a_i} - {1'b0, b_i};
  assign s_add = {a_i[W-1], a_i} + {b_i[W-1], b_i};
  assign s_sub = {a_i[W-1], a_i} - {b_i[W-1], b_i};

  // sign-extended result out of range when top two bits disagree
  function automatic logic [ERR_W-1:0] range_err(input logic [W:0] ext);
    if (ext[W] == ext[W-1]) return ERR_NONE;
    return ext[W] ? ERR_UNF : ERR_OVF;
  endfunction

  always_comb begin
    res_o = '0;
    err_o = ERR_NONE;
    unique case (op_i)
      OP_ADDU: begin res_o = u_add[W-1:0]; err_o = u_add[W] ? ERR_OVF : ERR_NONE; end
      OP_SUBU: begin res_o = u_sub[W-1:0]; err_o = u_sub[W] ? ERR_UNF : ERR_NONE; end
      OP_ADDS: begin res_o = s_add[W-1:0]; err_o = range_err(s_add); end
      OP_SUBS: begin res_o = s_sub[W-1:0]; err_o = range_err(s_sub); end
      default: ;
    endcase
  end
endmodule

// File: rtl/mop_alu_muldiv.sv
module mop_alu_muldiv
  import mop_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [W-1:0]     res_o,
  output logic [ERR_W-1:0] err_o
);
  localparam int         PW   = 2 * W;
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic signed [PW-1:0] a_ext, b_ext, prod;
  logic [W:0]           prod_top;
  logic                 prod_fits;
  logic                 div_zero, div_wrap;
  logic [W-1:0]         safe_b, quo;

  assign a_ext     = $signed({{W{a_i[W-1]}}, a_i});
  assign b_ext     = $signed({{W{b_i[W-1]}}, b_i});
  assign prod      = a_ext * b_ext;
  assign prod_top  = prod[PW-1:W-1];
  assign prod_fits = (&prod_top) | ~(|prod_top);

  assign div_zero = (b_i == '0);
  assign div_wrap = (a_i == SMIN) && (&b_i);
  // divisor forced to 1 for the two special cases; MIN/1 yields the wrapped MIN
  assign safe_b   = (div_zero || div_wrap) ? ONE : b_i;
  assign quo      = $signed(a_i) / $signed(safe_b);

  always_comb begin
    res_o = '0;
    err_o = ERR_NONE;
    unique case (op_i)
      OP_MULS: begin
        res_o = prod[W-1:0];
        if (!prod_fits) err_o = prod[PW-1] ? ERR_UNF : ERR_OVF;
      end
      OP_DIVS: begin
        res_o = div_zero ? '0 : quo;
        if (div_zero)      err_o = ERR_DIV0;
        else if (div_wrap) err_o = ERR_OVF;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mop_alu_logic.sv
module mop_alu_logic
  import mop_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [W-1:0]    res_o
);
  logic a_true, b_true;

  assign a_true = |a_i;
  assign b_true = |b_i;

  function automatic logic [W-1:0] as_word(input logic bit_v);
    return {{(W-1){1'b0}}, bit_v};
  endfunction

  always_comb begin
    res_o = '0;
    unique case (op_i)
      OP_LAND: res_o = as_word(a_true && b_true);
      OP_BAND: res_o = a_i & b_i;
      OP_LOR:  res_o = as_word(a_true || b_true);
      OP_BOR:  res_o = a_i | b_i;
      OP_LNOT: res_o = as_word(!a_true);
      OP_BNOT: res_o = ~a_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/mop_alu.sv
module mop_alu
  import mop_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]     opa_i,
  input  logic [W-1:0]     opb_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [W-1:0]     res_o,
  output logic [ERR_W-1:0] err_o
);
  logic [W-1:0]     as_res, md_res, lg_res;
  logic [ERR_W-1:0] as_err, md_err;

  mop_alu_addsub #(.W(W)) u_addsub (
    .a_i(opa_i), .b_i(opb_i), .op_i(op_i), .res_o(as_res), .err_o(as_err)
  );

  mop_alu_muldiv #(.W(W)) u_muldiv (
    .a_i(opa_i), .b_i(opb_i), .op_i(op_i), .res_o(md_res), .err_o(md_err)
  );

  mop_alu_logic #(.W(W)) u_logic (
    .a_i(opa_i), .b_i(opb_i), .op_i(op_i), .res_o(lg_res)
  );

  // each unit drives zero outside its own selectors, so OR-merge is a clean mux
  assign res_o = as_res | md_res | lg_res;
  assign err_o = as_err | md_err;
endmodule

// File: rtl/mop_alu_checker.sv
module mop_alu_checker
  import mop_alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic [W-1:0]     opa_i,
  input logic [W-1:0]     opb_i,
  input logic [OP_W-1:0]  op_i,
  input logic [W-1:0]     res_o,
  input logic [ERR_W-1:0] err_o
);
  always_comb begin
    if (!$isunknown({opa_i, opb_i, op_i})) begin
      a_r1_addu_carry: assert (op_i != OP_ADDU || ((err_o == ERR_OVF) == (res_o < opa_i)))
        else $error("R1 carry flag mismatch");
      a_r2_subu_borrow: assert (op_i != OP_SUBU || ((err_o == ERR_UNF) == (opb_i > opa_i)))
        else $error("R2 borrow flag mismatch");
      a_r7_div_zero: assert (op_i != OP_DIVS || opb_i != '0 || (res_o == '0 && err_o == ERR_DIV0))
        else $error("R7 divide by zero");
      a_r9_bool_shape: assert (!(op_i inside {OP_LAND, OP_LOR, OP_LNOT}) || res_o[W-1:1] == '0)
        else $error("R9 boolean result shape");
      a_r11_bnot_compl: assert (op_i != OP_BNOT || ((res_o & opa_i) == '0 && (&(res_o | opa_i))))
        else $error("R11 bitwise NOT");
      a_r12_unused_zero: assert (op_i < 4'd12 || (res_o == '0 && err_o == ERR_NONE))
        else $error("R12 unused selector");
      a_r12_logic_no_err: assert (op_i < 4'd6 || err_o == ERR_NONE)
        else $error("R12 logic error code");
      a_r13_err_range: assert (err_o <= ERR_DIV0)
        else $error("R13 error code range");
    end
  end
endmodule

bind mop_alu mop_alu_checker #(.W(W)) u_mop_alu_checker (
  .opa_i(opa_i), .opb_i(opb_i), .op_i(op_i), .res_o(res_o), .err_o(err_o)
);

// File: tb/mop_alu_bench.sv
module mop_alu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic [W-1:0] opa, opb, res;
  logic [3:0]   op, err;
  int           n_chk = 0, n_fail = 0;
  bit           done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mop_alu #(.W(W)) u_mop_alu (
    .opa_i(opa), .opb_i(opb), .op_i(op), .res_o(res), .err_o(err)
  );

  task automatic run(input string req, input logic [3:0] o, input logic [W-1:0] a,
                     input logic [W-1:0] b, input logic [W-1:0] exp_r, input logic [3:0] exp_e);
    op = o; opa = a; opb = b;
    #1;
    n_chk++;
    if (res !== exp_r || err !== exp_e) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h: res=%h err=%0d expected res=%h err=%0d",
               req, o, a, b, res, err, exp_r, exp_e);
    end
  endtask

  task automatic t_unsigned();
    run("R1", 4'd0, 32'd5, 32'd7, 32'd12, 4'd0);
    run("R1", 4'd0, 32'hFFFF_FFFF, 32'd2, 32'd1, 4'd1);
    run("R2", 4'd1, 32'd9, 32'd4, 32'd5, 4'd0);
    run("R2", 4'd1, 32'd4, 32'd9, 32'hFFFF_FFFB, 4'd2);
    run("R2", 4'd1, 32'd7, 32'd7, 32'd0, 4'd0);
  endtask

  task automatic t_signed_addsub();
    run("R3", 4'd2, 32'hFFFF_FFFD, 32'd5, 32'd2, 4'd0);
    run("R3", 4'd2, 32'h7FFF_FFFF, 32'd1, 32'h8000_0000, 4'd1);
    run("R3", 4'd2, 32'h8000_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 4'd2);
    run("R4", 4'd3, 32'd3, 32'd10, 32'hFFFF_FFF9, 4'd0);
    run("R4", 4'd3, 32'h8000_0000, 32'd1, 32'h7FFF_FFFF, 4'd2);
    run("R4", 4'd3, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000, 4'd1);
  endtask

  task automatic t_multiply();
    run("R5", 4'd4, 32'hFFFF_FFFA, 32'd7, 32'hFFFF_FFD6, 4'd0);
    run("R5", 4'd4, 32'h0001_0000, 32'h0001_0000, 32'd0, 4'd1);
    run("R5", 4'd4, 32'h0001_0000, 32'hFFFF_0000, 32'd0, 4'd2);
    run("R5", 4'd4, 32'h8000_0000, 32'd1, 32'h8000_0000, 4'd0);
    run("R5", 4'd4, 32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 4'd1);
  endtask

  task automatic t_divide();
    run("R6", 4'd5, 32'hFFFF_FFF9, 32'd2, 32'hFFFF_FFFD, 4'd0);
    run("R6", 4'd5, 32'd7, 32'hFFFF_FFFE, 32'hFFFF_FFFD, 4'd0);
    run("R6", 4'd5, 32'd2, 32'd7, 32'd0, 4'd0);
    run("R6", 4'd5, 32'd100, 32'd7, 32'd14, 4'd0);
    run("R7", 4'd5, 32'd5, 32'd0, 32'd0, 4'd3);
    run("R7", 4'd5, 32'd0, 32'd0, 32'd0, 4'd3);
    run("R8", 4'd5, 32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 4'd1);
  endtask

  task automatic t_logic();
    run("R9", 4'd6, 32'd5, 32'd0, 32'd0, 4'd0);
    run("R9", 4'd6, 32'd5, 32'd8, 32'd1, 4'd0);
    run("R9", 4'd8, 32'd0, 32'd0, 32'd0, 4'd0);
    run("R9", 4'd8, 32'd0, 32'h8000_0000, 32'd1, 4'd0);
    run("R10", 4'd7, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000, 4'd0);
    run("R10", 4'd9, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hFFF0_FFF0, 4'd0);
  endtask

  task automatic t_not();
    run("R11", 4'd10, 32'd0, 32'hFFFF_FFFF, 32'd1, 4'd0);
    run("R11", 4'd10, 32'd0, 32'd0, 32'd1, 4'd0);
    run("R11", 4'd10, 32'd4, 32'd0, 32'd0, 4'd0);
    run("R11", 4'd11, 32'hA5A5_A5A5, 32'd0, 32'h5A5A_5A5A, 4'd0);
    run("R11", 4'd11, 32'hA5A5_A5A5, 32'h1234_5678, 32'h5A5A_5A5A, 4'd0);
  endtask

  task automatic t_unused();
    for (int c = 12; c < 16; c++)
      run("R12", 4'(c), 32'hDEAD_BEEF, 32'h0000_0001, 32'd0, 4'd0);
  endtask

  task automatic t_follow();
    // inputs change between clock edges; outputs must track at once
    @(posedge clk); #2;
    run("R13", 4'd0, 32'd1, 32'd1, 32'd2, 4'd0);
    run("R13", 4'd0, 32'd1, 32'd3, 32'd4, 4'd0);
    run("R13", 4'd7, 32'd1, 32'd3, 32'd1, 4'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    op = 4'd15; opa = '0; opb = '0;
    #3;
    n_chk++;
    if (res !== '0 || err !== 4'd0) begin
      n_fail++;
      $display("FAIL R12 idle: res=%h err=%0d expected res=0 err=0", res, err);
    end
    t_unsigned();
    t_signed_addsub();
    t_multiply();
    t_divide();
    t_logic();
    t_not();
    t_unused();
    t_follow();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule